// File: doc/BRIEF.md
# NAND command and address sequencer

This block drives the control side of a large-page NAND flash bus that carries 8-bit or 16-bit data. It accepts one request at a time. A request holds an operation kind, a block number, a page within the block and a byte column. The block turns the request into a series of command bytes, marked by the command latch, and address bytes, marked by the address latch. Each byte is clocked out with a write-enable pulse of fixed length. The ready/busy line is watched wherever the flash needs time to finish.

A spare-area read needs no opcode of its own. It is issued as an ordinary page read whose column is moved past the end of the main page. On a 16-bit bus the column is given in words, so the byte offset is halved. A page read ends with a read-start confirm and a wait for the array fetch. A random data-out ends with its own confirm and does not wait. A reset sends a single opcode, then waits for the device to recover. Each request ends with a one-cycle done pulse. The data phase, error correction and datasheet timing are handled elsewhere.

Top module: `nand_cmd_seq`

## Requirements
- R1: After a request is accepted, no byte is strobed until the synchronized ready/busy input (high = ready) reports ready.
- R2: Command bytes are sent with the command latch high and the address latch low. Address bytes are sent with the address latch high and the command latch low. The two latches are never high together. Opcodes: page read 0x00 then confirm 0x30; random data-out 0x05 then confirm 0xE0; reset 0xFF.
- R3: A spare-area read (reqKind = 1) is sent with the page-read opcode 0x00 and confirm 0x30. Its column is the requested column plus PAGE_BYTES (2048).
- R4: When busWide16 is high at acceptance, the column (after any spare-area offset) is shifted right by one bit before it is sent.
- R5: The address bytes go out in this order: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8. With ADDR_CYCLES = 5, a fifth byte follows that carries row bits 19:16 in its low nibble and zeros in the high nibble.
- R6: The row equals reqBlock * PAGES_PER_BLOCK (64) + reqPage.
- R7: A page read and a reset each end with a wait for ready after the last byte. Done is not raised while the device reports busy. A reset (reqKind = 3) sends exactly one byte and no address bytes.
- R8: A random data-out (reqKind = 2) raises done after its confirm byte without waiting on ready/busy.
- R9: Each byte holds write-enable low for WE_LOW (2) clocks, then high for WE_HIGH clocks. The data, command latch and address latch are stable while write-enable is low. Chip enable is low for the whole request and high when idle, and no strobe occurs while chip enable is high.
- R10: A request is accepted only while idle is high. A request presented during a transfer is dropped and causes no byte and no done. Done is a one-cycle pulse, followed by idle.
- R11: After reset: idle = 1, done = 0, chip enable high, write-enable high, both latches low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqKind | input | 2 | 0 page read, 1 spare-area read, 2 random data-out, 3 reset |
| reqBlock | input | BLOCK_W (12) | Block number |
| reqPage | input | PAGE_W (6) | Page within the block |
| reqCol | input | COL_W (12) | Byte column offset |
| busWide16 | input | 1 | High when the flash bus is 16 bits wide |
| nandRb | input | 1 | Ready/busy from the device, asynchronous, high = ready |
| idle | output | 1 | High when a new request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low; the byte latches on its rising edge |
| nandIo | output | 8 | Command or address byte |

## Verification
The assertions take for granted that the request fields are sampled only in the cycle of acceptance. They also assume that ready/busy falls soon after a confirm or reset opcode, within the guard window, so that the final wait sees the busy phase. The bench models the device so that it drops ready/busy in the cycle that follows the rising write-enable of every 0x30 or 0xFF command byte. It changes the request fields only in the cycle in which reqValid is driven. Stray requests during a transfer are driven on purpose to show that they are dropped.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    REQ_PAGE_READ = 2'd0,
    REQ_OOB_READ  = 2'd1,
    REQ_RAND_OUT  = 2'd2,
    REQ_RESET     = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    SEL_OPCODE  = 2'd0,
    SEL_ADDRESS = 2'd1,
    SEL_CONFIRM = 2'd2
  } byteSel_e;

  // Strobes from the control FSM to the address datapath
  typedef struct packed {
    logic     load;
    byteSel_e sel;
    logic [2:0] addrIdx;
  } seqStrobe_t;

  localparam logic [7:0] OPC_READ       = 8'h00;
  localparam logic [7:0] OPC_READ_START = 8'h30;
  localparam logic [7:0] OPC_RAND_OUT   = 8'h05;
  localparam logic [7:0] OPC_RAND_START = 8'hE0;
  localparam logic [7:0] OPC_RESET      = 8'hFF;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rbAsync,
  output logic rbReady
);
  logic [STAGES-1:0] syncReg;

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[STAGES-2:0], rbAsync};
  end

  assign rbReady = syncReg[STAGES-1];
endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int BLOCK_W         = 12,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 12,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [1:0]         reqKind,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [COL_W-1:0]   reqCol,
  input  logic               busWide16,
  output reqKind_e           kindLatched,
  output logic [7:0]         ioByte
);
  localparam int COLX_W = 16;
  localparam int ROW_W  = 20;

  reqKind_e            kindIn;
  logic [COLX_W-1:0]   colExt;
  logic [COLX_W-1:0]   colFinal;
  logic [ROW_W-1:0]    rowCalc;
  logic [COLX_W-1:0]   colReg;
  logic [ROW_W-1:0]    rowReg;
  reqKind_e            kindReg;

  assign kindIn = reqKind_e'(reqKind);

  always_comb begin
    colExt   = COLX_W'(reqCol) +
               ((kindIn == REQ_OOB_READ) ? COLX_W'(PAGE_BYTES) : '0);
    colFinal = busWide16 ? (colExt >> 1) : colExt;
    rowCalc  = ROW_W'(reqBlock) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(reqPage);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colReg  <= '0;
      rowReg  <= '0;
      kindReg <= REQ_PAGE_READ;
    end else if (strobe.load) begin
      colReg  <= colFinal;
      rowReg  <= rowCalc;
      kindReg <= (kindIn == REQ_OOB_READ) ? REQ_PAGE_READ : kindIn;
    end
  end

  assign kindLatched = kindReg;

  always_comb begin
    ioByte = 8'h00;
    unique case (strobe.sel)
      SEL_OPCODE: begin
        case (kindReg)
          REQ_RAND_OUT: ioByte = OPC_RAND_OUT;
          REQ_RESET:    ioByte = OPC_RESET;
          default:      ioByte = OPC_READ;
        endcase
      end
      SEL_CONFIRM:
        ioByte = (kindReg == REQ_RAND_OUT) ? OPC_RAND_START : OPC_READ_START;
      SEL_ADDRESS: begin
        case (strobe.addrIdx)
          3'd0:    ioByte = colReg[7:0];
          3'd1:    ioByte = colReg[15:8];
          3'd2:    ioByte = rowReg[7:0];
          3'd3:    ioByte = rowReg[15:8];
          default: ioByte = {4'h0, rowReg[19:16]};
        endcase
      end
      default: ioByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int GUARD_CYC   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rbReady,
  input  reqKind_e   kind,
  output seqStrobe_t strobe,
  output logic       nandCeN,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       idle,
  output logic       done
);
  localparam int BYTE_CYC = WE_LOW + WE_HIGH;
  localparam int CNT_W    = $clog2(BYTE_CYC + GUARD_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_PRE, ST_CMD, ST_ADDR, ST_CONF, ST_GUARD, ST_WAIT_POST, ST_DONE
  } seqState_e;

  seqState_e      state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]     addrIdx;
  logic           byteState;
  logic           byteEnd;

  assign byteState = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_CONF);
  assign byteEnd   = byteState && (cnt == CNT_W'(BYTE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addrIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:     if (reqValid) state <= ST_WAIT_PRE;
        ST_WAIT_PRE: if (rbReady) begin
                       state <= ST_CMD;
                       cnt   <= '0;
                     end
        ST_CMD: begin
          if (byteEnd) begin
            cnt     <= '0;
            addrIdx <= '0;
            state   <= (kind == REQ_RESET) ? ST_GUARD : ST_ADDR;
          end else cnt <= cnt + 1'b1;
        end
        ST_ADDR: begin
          if (byteEnd) begin
            cnt <= '0;
            if (addrIdx == 3'(ADDR_CYCLES - 1)) state <= ST_CONF;
            else addrIdx <= addrIdx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_CONF: begin
          if (byteEnd) begin
            cnt   <= '0;
            state <= (kind == REQ_RAND_OUT) ? ST_DONE : ST_GUARD;
          end else cnt <= cnt + 1'b1;
        end
        ST_GUARD: begin
          if (cnt == CNT_W'(GUARD_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_WAIT_POST;
          end else cnt <= cnt + 1'b1;
        end
        ST_WAIT_POST: if (rbReady) state <= ST_DONE;
        ST_DONE:      state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.addrIdx = addrIdx;
    unique case (state)
      ST_ADDR: strobe.sel = SEL_ADDRESS;
      ST_CONF: strobe.sel = SEL_CONFIRM;
      default: strobe.sel = SEL_OPCODE;
    endcase
  end

  assign idle    = (state == ST_IDLE);
  assign done    = (state == ST_DONE);
  assign nandCeN = (state == ST_IDLE);
  assign nandCle = (state == ST_CMD) || (state == ST_CONF);
  assign nandAle = (state == ST_ADDR);
  assign nandWeN = !(byteState && (cnt < CNT_W'(WE_LOW)));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int BLOCK_W         = 12,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 12,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ADDR_CYCLES     = 5,
  parameter int WE_LOW          = 2,
  parameter int WE_HIGH         = 2,
  parameter int GUARD_CYC       = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [BLOCK_W-1:0] reqBlock,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [COL_W-1:0]   reqCol,
  input  logic               busWide16,
  input  logic               nandRb,
  output logic               idle,
  output logic               done,
  output logic               nandCeN,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic [7:0]         nandIo
);
  seqStrobe_t strobe;
  reqKind_e   kindLatched;
  logic       rbReady;

  nand_rb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .rbAsync(nandRb), .rbReady(rbReady)
  );

  nand_seq_ctrl #(
    .ADDR_CYCLES(ADDR_CYCLES), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .GUARD_CYC(GUARD_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rbReady(rbReady), .kind(kindLatched),
    .strobe(strobe), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .idle(idle), .done(done)
  );

  nand_seq_dp #(
    .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind), .reqBlock(reqBlock),
    .reqPage(reqPage), .reqCol(reqCol), .busWide16(busWide16),
    .kindLatched(kindLatched), .ioByte(nandIo)
  );
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       idle,
  input logic       done,
  input logic       nandCeN,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic [7:0] nandIo
);
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_strobe_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> ($stable(nandIo) && $stable(nandCle) && $stable(nandAle)));

  assert_quiet_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    nandCeN |-> (nandWeN && !nandCle && !nandAle));

  assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> nandCeN);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && idle));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid) |=> !idle);
endmodule

bind nand_cmd_seq nand_seq_checker i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .idle(idle), .done(done),
  .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
  .nandIo(nandIo)
);

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/100ps
module test_nand_cmd_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [11:0] reqBlock = '0;
  logic [5:0]  reqPage = '0;
  logic [11:0] reqCol = '0;
  logic        busWide16 = 1'b0;
  logic        nandRb;
  logic        idle, done, nandCeN, nandCle, nandAle, nandWeN;
  logic [7:0]  nandIo;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  int logCnt = 0;
  int doneCnt = 0;
  int doneCycle = 0;
  int confCycle = 0;
  int busyLeft = 0;
  int busyLen = 6;
  int lowLen = 0;
  int weErr = 0;
  bit rbHold = 1'b0;
  logic prevWe = 1'b1;
  logic [9:0] logBuf [0:2047];

  always #2.5 clk = ~clk;

  assign nandRb = (busyLeft == 0) && !rbHold;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqBlock(reqBlock),
    .reqPage(reqPage), .reqCol(reqCol), .busWide16(busWide16), .nandRb(nandRb),
    .idle(idle), .done(done), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandIo(nandIo)
  );

  // Device model and bus monitor
  always @(negedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", cycle);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
    if (rstN) begin
      if (!nandWeN) lowLen++;
      if (!prevWe && nandWeN) begin
        logBuf[logCnt & 2047] = {nandCle, nandAle, nandIo};
        logCnt++;
        if (lowLen != 2) weErr++;
        lowLen = 0;
        if (nandCle && (nandIo == 8'h30 || nandIo == 8'hFF)) begin
          busyLeft = busyLen;
          confCycle = cycle;
        end
      end else if (busyLeft > 0) busyLeft--;
      if (done) begin
        doneCnt++;
        doneCycle = cycle;
      end
      prevWe = nandWeN;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int expCount(input int kind);
    return (kind == 3) ? 1 : 7;
  endfunction

  // Expected {cle, ale, io} of byte idx, from the requirements
  function automatic logic [9:0] expEntry(input int kind, input int blk, input int pg,
                                          input int col, input bit wide, input int idx);
    int c = col + ((kind == 1) ? 2048 : 0);
    int row = blk * 64 + pg;
    if (wide) c = c >> 1;
    if (kind == 3) return {2'b10, 8'hFF};
    case (idx)
      0: return {2'b10, (kind == 2) ? 8'h05 : 8'h00};
      1: return {2'b01, 8'(c)};
      2: return {2'b01, 8'(c >> 8)};
      3: return {2'b01, 8'(row)};
      4: return {2'b01, 8'(row >> 8)};
      5: return {2'b01, 4'h0, 4'(row >> 16)};
      default: return {2'b10, (kind == 2) ? 8'hE0 : 8'h30};
    endcase
  endfunction

  task automatic waitDone(input int base, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (doneCnt > base) begin ok = 1'b1; break; end
    end
  endtask

  // One request; optional stray request mid-transfer; optional hold of ready after first byte
  task automatic runReq(input int kind, input int blk, input int pg, input int col,
                        input bit wide, input bit stray, input bit holdAfterFirst,
                        input string tag);
    int startIdx = logCnt;
    int base = doneCnt;
    bit ok;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'(kind); reqBlock = 12'(blk);
    reqPage = 6'(pg); reqCol = 12'(col); busWide16 = wide;
    @(negedge clk);
    reqValid = 1'b0;
    reqBlock = '1; reqCol = '1; reqPage = '1; busWide16 = ~wide;
    if (stray) begin
      repeat (5) @(negedge clk);
      reqValid = 1'b1; reqKind = 2'd3;
      @(negedge clk);
      reqValid = 1'b0;
    end
    if (holdAfterFirst) begin
      while (logCnt == startIdx) @(negedge clk);
      rbHold = 1'b1;
    end
    waitDone(base, ok);
    check(ok, tag, "done seen", int'(ok), 1);
    if (kind == 3 || kind <= 1)
      check(doneCycle - confCycle >= busyLen, "R7", "done after busy end",
            doneCycle - confCycle, busyLen);
    repeat (12) @(negedge clk);
    rbHold = 1'b0;
    check(logCnt - startIdx == expCount(kind), (kind == 3) ? "R7" : tag, "byte count",
          logCnt - startIdx, expCount(kind));
    for (int i = 0; i < expCount(kind) && i < logCnt - startIdx; i++) begin
      logic [9:0] e = expEntry(kind, blk, pg, col, wide, i);
      logic [9:0] a = logBuf[(startIdx + i) & 2047];
      check(a == e, (i >= 1 && i <= 5) ? "R5" : "R2", $sformatf("%s byte %0d", tag, i),
            int'(a), int'(e));
    end
    check(doneCnt == base + 1 && idle, "R10", "single done then idle", doneCnt - base, 1);
  endtask

  initial begin
    int startIdx;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(idle && !done && nandCeN && nandWeN && !nandCle && !nandAle, "R11",
          "reset outputs", {idle, done, nandCeN, nandWeN, nandCle, nandAle}, 6'b101100);

    // R1: hold device busy; nothing may be strobed
    rbHold = 1'b1;
    startIdx = logCnt;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd0; reqBlock = 12'd3; reqPage = 6'd1; reqCol = 12'd0;
    busWide16 = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    check(logCnt == startIdx, "R1", "no byte while busy", logCnt - startIdx, 0);
    rbHold = 1'b0;
    begin
      bit ok;
      waitDone(doneCnt, ok);
      check(ok, "R1", "completes after ready", int'(ok), 1);
      check(logCnt - startIdx == 7, "R1", "byte count after ready", logCnt - startIdx, 7);
      check(logBuf[(startIdx + 3) & 2047] == {2'b01, 8'd193}, "R6", "row low 3*64+1",
            int'(logBuf[(startIdx + 3) & 2047]), {2'b01, 8'd193});
    end
    repeat (4) @(negedge clk);

    // Directed corners
    busyLen = 10;
    runReq(0, 4095, 63, 4095, 1'b0, 1'b0, 1'b0, "R6");   // max row, fifth byte nibble
    runReq(1, 7, 2, 5, 1'b0, 1'b0, 1'b0, "R3");          // spare-area read
    runReq(1, 7, 2, 5, 1'b1, 1'b0, 1'b0, "R4");          // spare-area, 16-bit
    runReq(0, 1, 1, 4094, 1'b1, 1'b0, 1'b0, "R4");       // halved column
    runReq(2, 9, 9, 513, 1'b0, 1'b0, 1'b1, "R8");        // random out, busy after start
    runReq(3, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R7");          // reset
    runReq(0, 100, 7, 64, 1'b0, 1'b1, 1'b0, "R10");      // stray request dropped
    check(weErr == 0, "R9", "write-enable low width", weErr, 0);

    // Constrained random mix
    for (int n = 0; n < 30; n++) begin
      int r = $urandom % 8;
      int k = (r < 3) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
      busyLen = 3 + ($urandom % 10);
      runReq(k, $urandom % 4096, $urandom % 64, $urandom % 4096, 1'($urandom % 2),
             1'($urandom % 4 == 0), 1'b0, "R2");
    end
    check(weErr == 0, "R9", "write-enable low width after random", weErr, 0);
    check(idle && nandCeN, "R9", "deselected when idle", {idle, nandCeN}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule